// File: doc/BRIEF.md
# Vectored interrupt controller

This block sits beside a processor core and decides which peripheral interrupt the core should service next. Each of up to twenty sources raises a pending flag with a one-cycle event pulse. A flag counts as a request only while its own enable bit is set and the global interrupt-enable bit is also set. When the core signals that it can accept an interrupt, the controller picks the enabled pending source with the lowest index and registers that source's vector word address. It raises a one-cycle acknowledge and clears the global enable bit, all on the same clock edge, so nested interrupts cannot start.

Vectors are laid out two words apart, beginning at word address 0x0002. Source `i` therefore dispatches to word address `2 + 2*i`, and the last of twenty sources lands at 0x0028. Sources marked as self-clearing have their pending flag cleared by hardware on the dispatch edge. The timer-0 overflow source, index 8 at vector 0x0012, is one of these by default. Other sources keep their flag until the handler clears it. A return-from-interrupt strobe sets the global enable again, and software can also write the global enable directly.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, all pending flags, all per-source enables, the global enable, the acknowledge and the vector output are 0.
- R2: A pulse on `srcEvent[i]` sets flag `i` at the next edge, and a pulse on `srcClear[i]` clears it. When an event coincides with a clear or with a hardware auto-clear of the same flag, the event wins and the flag stays 1.
- R3: While the global enable is 0, no acknowledge is issued and pending flags are left unchanged.
- R4: A pending source whose enable bit is 0 is never dispatched, and its flag is kept. A source is dispatched only when its flag and its enable bit are both 1.
- R5: A dispatch happens at the first edge at which the global enable is 1, `coreReady` is 1 and some enabled flag is pending. At that edge `ackOut` goes to 1 for exactly one cycle and the global enable goes to 0.
- R6: The dispatched vector is word address `2 + 2*i` for source `i`: source 0 gives 0x0002, source 8 (timer-0 overflow) gives 0x0012, and source 19 gives 0x0028.
- R7: When several enabled flags are pending together, the source with the lowest index, and so the lowest vector address, is dispatched in a single cycle.
- R8: On the dispatch edge the flag of the dispatched source is cleared if it is self-clearing (default mask: only bit 8). A source that is not self-clearing keeps its flag.
- R9: `vecOut` changes only on a dispatch edge and holds its value between dispatches.
- R10: A write on `gieWrite` or a `retStb` pulse takes effect at the next edge, and `retStb` takes priority over a write. A dispatch on the same edge takes priority over both, and the global enable ends at 0.
- R11: While `coreReady` is 0, no dispatch occurs, and the global enable and flags are held.
- R12: A request still pending after a dispatch is not taken until the global enable has been set again. It is then dispatched at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcEvent | input | 20 | Per-source event pulses that set the pending flags |
| srcClear | input | 20 | Per-source clear pulses from software |
| enWrite | input | 1 | Load strobe for the per-source enable register |
| enData | input | 20 | New per-source enable value |
| gieWrite | input | 1 | Load strobe for the global enable bit |
| gieData | input | 1 | New global enable value |
| retStb | input | 1 | Return-from-interrupt pulse; sets the global enable |
| coreReady | input | 1 | Core can take an interrupt this cycle |
| ackOut | output | 1 | One-cycle dispatch acknowledge |
| vecOut | output | 16 | Word address of the last dispatched vector |
| gieOut | output | 1 | Current global enable (status bit 7) |
| flagOut | output | 20 | Current pending flags |

## Verification
Dispatch is tried with a single enabled source and with several enabled sources pending together. The single-source case checks the vector arithmetic and the self-clear path. The multi-source case separates the lowest-index choice from other orderings, and it separates sources that clear their own flag from those that keep it. Pending flags are also held under each blocking condition in turn: global enable off, source enable off, and core not ready. This shows that each gate blocks dispatch on its own. Coincident stimuli check the stated priorities: an event arriving on its own auto-clear edge, and a set of the global enable on a dispatch edge.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;
  // strobes from control to datapath, both asserted on a dispatch cycle
  typedef struct packed {
    logic take;     // clear the winner's flag if self-clearing
    logic loadVec;  // capture the winner's vector
  } ctlStrobes_t;
endpackage

// File: rtl/irq_vector_datapath.sv
module irq_vector_datapath
  import irq_vector_pkg::*;
#(
  parameter int NUM_SRC = 20,
  parameter int ADDR_W = 16,
  parameter int VEC_BASE = 2,
  parameter int VEC_STRIDE = 2,
  parameter logic [NUM_SRC-1:0] SELF_CLR_MASK = NUM_SRC'(20'h00100)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEvent,
  input  logic [NUM_SRC-1:0] srcClear,
  input  logic               enWrite,
  input  logic [NUM_SRC-1:0] enData,
  input  ctlStrobes_t        strb,
  output logic               anyPend,
  output logic [NUM_SRC-1:0] flagOut,
  output logic [ADDR_W-1:0]  vecOut
);
  localparam int IDX_W = $clog2(NUM_SRC);
  localparam logic [ADDR_W-1:0] VEC_LO = ADDR_W'(VEC_BASE);
  localparam logic [ADDR_W-1:0] VEC_HI = ADDR_W'(VEC_BASE + VEC_STRIDE * (NUM_SRC - 1));

  logic [NUM_SRC-1:0] flagQ, flagNext, enQ, pend, lowerAny, winOH, autoClr;
  logic [IDX_W-1:0]   winIdx;
  logic [ADDR_W-1:0]  vecQ, vecNext;

  assign pend    = flagQ & enQ;
  assign anyPend = |pend;

  // lowest index wins: a source wins when no lower source is pending
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
    if (i == 0) begin : g_first
      assign lowerAny[i] = 1'b0;
    end else begin : g_rest
      assign lowerAny[i] = |pend[i-1:0];
    end
    assign winOH[i] = pend[i] & ~lowerAny[i];
  end

  always_comb begin
    winIdx = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (winOH[k]) winIdx = IDX_W'(k);
    end
  end

  assign vecNext = VEC_LO + ADDR_W'(VEC_STRIDE) * ADDR_W'(winIdx);

  // flag update: a new event beats any clear on the same edge
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    assign autoClr[i]  = strb.take & winOH[i] & SELF_CLR_MASK[i];
    assign flagNext[i] = srcEvent[i] | (flagQ[i] & ~srcClear[i] & ~autoClr[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
      enQ   <= '0;
      vecQ  <= '0;
    end else begin
      flagQ <= flagNext;
      if (enWrite) enQ <= enData;
      if (strb.loadVec) vecQ <= vecNext;
    end
  end

  assign flagOut = flagQ;
  assign vecOut  = vecQ;

  assert_win_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(winOH) && ((|winOH) == anyPend));

  assert_only_enabled_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |-> |(flagQ & enQ));

  assert_flags_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.take && !(|srcEvent) && !(|srcClear)) |=> $stable(flagQ));

  assert_vec_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadVec |=> $stable(vecQ));

  assert_vec_in_table_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadVec |=> (vecQ >= VEC_LO && vecQ <= VEC_HI));

  assert_self_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.take && |(winOH & SELF_CLR_MASK & ~srcEvent)) |=> ((flagQ & $past(winOH)) == '0));
endmodule

// File: rtl/irq_vector_control.sv
module irq_vector_control
  import irq_vector_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        anyPend,
  input  logic        coreReady,
  input  logic        gieWrite,
  input  logic        gieData,
  input  logic        retStb,
  output ctlStrobes_t strb,
  output logic        ackOut,
  output logic        gieOut
);
  logic gieQ, gieNext, ackQ, take;

  assign take = anyPend & gieQ & coreReady;

  // dispatch clear beats return strobe, which beats a software write
  always_comb begin
    gieNext = gieQ;
    if (gieWrite) gieNext = gieData;
    if (retStb)   gieNext = 1'b1;
    if (take)     gieNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gieQ <= 1'b0;
      ackQ <= 1'b0;
    end else begin
      gieQ <= gieNext;
      ackQ <= take;
    end
  end

  assign strb.take    = take;
  assign strb.loadVec = take;
  assign ackOut = ackQ;
  assign gieOut = gieQ;

  assert_ack_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    ackQ |=> !ackQ);

  assert_ack_drops_gie_R5: assert property (@(posedge clk) disable iff (!rstN)
    ackQ |-> !gieQ);

  assert_no_take_gie_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    !gieQ |=> !ackQ);

  assert_reti_sets_R10: assert property (@(posedge clk) disable iff (!rstN)
    (retStb && !take) |=> gieQ);

  assert_ready_gate_R11: assert property (@(posedge clk) disable iff (!rstN)
    !coreReady |=> !ackQ);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vector_pkg::*;
#(
  parameter int NUM_SRC = 20,
  parameter int ADDR_W = 16,
  parameter int VEC_BASE = 2,
  parameter int VEC_STRIDE = 2,
  parameter logic [NUM_SRC-1:0] SELF_CLR_MASK = NUM_SRC'(20'h00100)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEvent,
  input  logic [NUM_SRC-1:0] srcClear,
  input  logic               enWrite,
  input  logic [NUM_SRC-1:0] enData,
  input  logic               gieWrite,
  input  logic               gieData,
  input  logic               retStb,
  input  logic               coreReady,
  output logic               ackOut,
  output logic [ADDR_W-1:0]  vecOut,
  output logic               gieOut,
  output logic [NUM_SRC-1:0] flagOut
);
  ctlStrobes_t strb;
  logic        anyPend;

  irq_vector_control u_ctl (
    .clk(clk), .rstN(rstN), .anyPend(anyPend), .coreReady(coreReady),
    .gieWrite(gieWrite), .gieData(gieData), .retStb(retStb),
    .strb(strb), .ackOut(ackOut), .gieOut(gieOut)
  );

  irq_vector_datapath #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE),
    .VEC_STRIDE(VEC_STRIDE), .SELF_CLR_MASK(SELF_CLR_MASK)
  ) u_dp (
    .clk(clk), .rstN(rstN), .srcEvent(srcEvent), .srcClear(srcClear),
    .enWrite(enWrite), .enData(enData), .strb(strb),
    .anyPend(anyPend), .flagOut(flagOut), .vecOut(vecOut)
  );
endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] srcEvent = '0, srcClear = '0, enData = '0;
  logic        enWrite = 1'b0, gieWrite = 1'b0, gieData = 1'b0, retStb = 1'b0, coreReady = 1'b0;
  logic        ackOut, gieOut;
  logic [15:0] vecOut;
  logic [19:0] flagOut;
  int nChecks = 0, nFail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  irq_vector_ctrl u0 (
    .clk(clk), .rstN(rstN), .srcEvent(srcEvent), .srcClear(srcClear),
    .enWrite(enWrite), .enData(enData), .gieWrite(gieWrite), .gieData(gieData),
    .retStb(retStb), .coreReady(coreReady), .ackOut(ackOut), .vecOut(vecOut),
    .gieOut(gieOut), .flagOut(flagOut)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic release_strobes();
    srcEvent = '0; srcClear = '0; enWrite = 1'b0; gieWrite = 1'b0; retStb = 1'b0;
  endtask

  task automatic cleanup();
    srcClear = '1; enWrite = 1'b1; enData = '0; gieWrite = 1'b1; gieData = 1'b0; coreReady = 1'b0;
    tick();
    release_strobes();
  endtask

  task automatic t_reset();
    check("R1 flags", 32'(flagOut), 0);
    check("R1 gie", 32'(gieOut), 0);
    check("R1 ack", 32'(ackOut), 0);
    check("R1 vec", 32'(vecOut), 0);
  endtask

  task automatic t_flags();
    srcEvent = 20'h00022; tick(); release_strobes();
    check("R2 set", 32'(flagOut), 32'h22);
    srcClear = 20'h00002; tick(); release_strobes();
    check("R2 clear", 32'(flagOut), 32'h20);
    srcEvent = 20'h00020; srcClear = 20'h00020; tick(); release_strobes();
    check("R2 event beats clear", 32'(flagOut), 32'h20);
    cleanup();
  endtask

  task automatic t_gie_off();
    enWrite = 1'b1; enData = '1; srcEvent = 20'h00020; coreReady = 1'b1;
    tick(); release_strobes();
    repeat (3) tick();
    check("R3 no ack gie off", 32'(ackOut), 0);
    check("R3 flag held", 32'(flagOut), 32'h20);
    cleanup();
  endtask

  task automatic t_disabled();
    enWrite = 1'b1; enData = 20'h00040; gieWrite = 1'b1; gieData = 1'b1;
    srcEvent = 20'h00008; coreReady = 1'b1;
    tick(); release_strobes();
    repeat (3) tick();
    check("R4 disabled no ack", 32'(ackOut), 0);
    check("R4 disabled flag kept", 32'(flagOut), 32'h8);
    check("R4 gie kept", 32'(gieOut), 1);
    srcEvent = 20'h00040; tick(); release_strobes();
    tick();
    check("R4 enabled ack", 32'(ackOut), 1);
    check("R4 enabled vec", 32'(vecOut), 32'h0E);
    cleanup();
  endtask

  task automatic t_basic();
    enWrite = 1'b1; enData = 20'h00100; gieWrite = 1'b1; gieData = 1'b1; srcEvent = 20'h00100;
    tick(); release_strobes();
    check("R10 write gie", 32'(gieOut), 1);
    coreReady = 1'b1; tick();
    check("R5 ack", 32'(ackOut), 1);
    check("R5 gie cleared", 32'(gieOut), 0);
    check("R6 timer vec", 32'(vecOut), 32'h12);
    check("R8 self clear", 32'(flagOut), 0);
    tick();
    check("R5 ack one cycle", 32'(ackOut), 0);
    check("R9 vec held", 32'(vecOut), 32'h12);
    cleanup();
  endtask

  task automatic t_priority();
    enWrite = 1'b1; enData = 20'h80411; srcEvent = 20'h80410;
    tick(); release_strobes();
    retStb = 1'b1; tick(); release_strobes();
    check("R10 reti sets gie", 32'(gieOut), 1);
    coreReady = 1'b1; tick();
    check("R7 lowest wins ack", 32'(ackOut), 1);
    check("R7 lowest wins vec", 32'(vecOut), 32'h0A);
    check("R8 not self clearing kept", 32'(flagOut), 32'h80410);
    repeat (3) tick();
    check("R12 no retake", 32'(ackOut), 0);
    check("R9 vec stable", 32'(vecOut), 32'h0A);
    srcClear = 20'h00010; gieWrite = 1'b1; gieData = 1'b1; tick(); release_strobes();
    check("R12 gie back", 32'(gieOut), 1);
    check("R12 not yet", 32'(ackOut), 0);
    tick();
    check("R12 next dispatch", 32'(ackOut), 1);
    check("R6 vec src10", 32'(vecOut), 32'h16);
    srcClear = 20'h00400; retStb = 1'b1; tick(); release_strobes();
    tick();
    check("R6 top vec", 32'(vecOut), 32'h28);
    srcClear = 20'h80000; srcEvent = 20'h00001; retStb = 1'b1; tick(); release_strobes();
    tick();
    check("R6 bottom vec", 32'(vecOut), 32'h02);
    cleanup();
  endtask

  task automatic t_ready();
    enWrite = 1'b1; enData = 20'h00008; srcEvent = 20'h00008; gieWrite = 1'b1; gieData = 1'b1;
    tick(); release_strobes();
    repeat (3) tick();
    check("R11 not ready no ack", 32'(ackOut), 0);
    check("R11 gie held", 32'(gieOut), 1);
    check("R11 flag held", 32'(flagOut), 32'h8);
    coreReady = 1'b1; tick();
    check("R11 ready ack", 32'(ackOut), 1);
    check("R11 vec", 32'(vecOut), 32'h08);
    cleanup();
  endtask

  task automatic t_same_edge();
    enWrite = 1'b1; enData = 20'h00100; srcEvent = 20'h00100; gieWrite = 1'b1; gieData = 1'b1;
    tick(); release_strobes();
    coreReady = 1'b1; srcEvent = 20'h00100; gieWrite = 1'b1; gieData = 1'b1; retStb = 1'b1;
    tick(); release_strobes();
    check("R10 dispatch beats set ack", 32'(ackOut), 1);
    check("R10 dispatch beats set gie", 32'(gieOut), 0);
    check("R2 event beats auto clear", 32'(flagOut), 32'h100);
    cleanup();
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    rstN = 1'b1;
    tick();
    t_reset();
    t_flags();
    t_gie_off();
    t_disabled();
    t_basic();
    t_priority();
    t_ready();
    t_same_edge();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end
endmodule